// File: doc/BRIEF.md
# Address-Latched Cartridge Bank Mapper

This block performs bank switching for an 8-bit console cartridge. It watches CPU writes to the upper 32 KB of the CPU address space and takes its command from the low byte of the write address itself. The data bus is ignored. The command byte is split into two nibbles. The upper nibble is an operation code, and the lower nibble is a bank number N.

Which operation codes are accepted depends on where the write lands. In the region from 0x9000 upward, code 0xD loads the program bank and code 0xE loads the character bank. In the region 0x8000 to 0x8FFF, code 0xB loads the program bank and code 0x7 loads the character bank. Any other code leaves the bank state alone.

The CPU window is made of four 8 KB slots. The lower 16 KB is fixed. The upper 16 KB follows the program bank. The video side has eight 1 KB slots that follow one 8 KB-aligned character base. The block translates the CPU and video addresses into program-ROM and character-ROM addresses. The ROM sizes are parameters, and the ROM arrays themselves live outside the block.

Top module: `addr_latched_bank_mapper`

## Requirements
- R1: After reset, CPU slots 0, 1, 2 and 3 map to 8 KB program pages 0, 1, PRG_PAGES-2 and PRG_PAGES-1. Slot number = cpu_addr[14:13].
- R2: After reset, video slot k (ppu_addr[12:10]) maps to 1 KB character page k, for k = 0 to 7.
- R3: The command byte is cpu_addr[7:0]. The bank number N is bits [3:0] and the operation code is bits [7:4]. The value on cpu_wdata never affects any mapping.
- R4: A qualified write with cpu_addr >= 0x9000 loads the program bank when the operation code is 0xD, and loads the character bank when the code is 0xE.
- R5: A qualified write with cpu_addr in 0x8000 to 0x8FFF loads the program bank when the operation code is 0xB, and loads the character bank when the code is 0x7.
- R6: Any other operation code for the region of the write leaves every mapping unchanged. This includes the codes that are valid only in the other region.
- R7: A program-bank load maps slot 2 to page (2N mod PRG_PAGES) and slot 3 to the page after it.
- R8: A character-bank load maps video slot k to page (8N mod CHR_PAGES) + k.
- R9: CPU slots 0 and 1 always map to pages 0 and 1.
- R10: A write is qualified only when cpu_wr is high and cpu_addr[15] is 1. The mapping changes on the clock edge that samples such a write, and at no other time.
- R11: prg_addr = {slot page, cpu_addr[12:0]} and chr_addr = {slot page, ppu_addr[9:0]}. Both are combinational from the current registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU address; the low byte carries the command |
| cpu_wdata | input | 8 | CPU write data (ignored) |
| ppu_addr | input | 13 | Video address inside the 8 KB pattern space |
| prg_addr | output | $clog2(PRG_PAGES)+13 | Translated program-ROM address |
| chr_addr | output | $clog2(CHR_PAGES)+10 | Translated character-ROM address |

## Verification
A wrong program base shows up at once on prg_addr for any CPU address in the upper 16 KB. A wrong character base shows up on chr_addr for every video address. Because both outputs are combinational, a bad register update is visible in the cycle right after the offending write.

A decode fault is seen in one of two ways. Either a rejected operation code moves a base, or an accepted one leaves it in place. The bench probes every slot after directed writes. It also probes random slots after random writes, where both region-dependent code sets are mixed in. A fault in the modulo wrap appears only for bank numbers past the ROM size, so those numbers are driven on purpose.

// File: rtl/abm_pkg.sv
// Package: abm_pkg
// Shared constants and types for the address-latched bank mapper.
// Assumes the command byte is the CPU address low byte:
// bits [7:4] hold the operation code and bits [3:0] the bank number.
package abm_pkg;
    localparam logic [15:0] REGION_SPLIT = 16'h9000;
    localparam logic [3:0]  OP_PRG_UP    = 4'hD;
    localparam logic [3:0]  OP_CHR_UP    = 4'hE;
    localparam logic [3:0]  OP_PRG_LOW   = 4'hB;
    localparam logic [3:0]  OP_CHR_LOW   = 4'h7;

    typedef enum logic [1:0] {
        CMD_NONE = 2'd0,
        CMD_PRG  = 2'd1,
        CMD_CHR  = 2'd2
    } cmd_kind_e;
endpackage

// File: rtl/abm_cmd_decode.sv
// Module: abm_cmd_decode
// Turns a qualified CPU write into a one-cycle program or character load.
// The address region picks which operation codes are accepted.
// Assumes wr_qual already includes the A15 check.
module abm_cmd_decode
    import abm_pkg::*;
(
    input  logic        wr_qual,
    input  logic [15:0] cpu_addr,
    output logic        prg_load,
    output logic        chr_load,
    output logic [3:0]  bank_nib
);
    cmd_kind_e  kind;
    logic       upper;
    logic [3:0] op;

    // Classify the command by region and operation code.
    always_comb begin
        upper = (cpu_addr >= REGION_SPLIT);
        op    = cpu_addr[7:4];
        kind  = CMD_NONE;
        if (upper) begin
            case (op)
                OP_PRG_UP: kind = CMD_PRG;
                OP_CHR_UP: kind = CMD_CHR;
                default:   kind = CMD_NONE;
            endcase
        end else begin
            case (op)
                OP_PRG_LOW: kind = CMD_PRG;
                OP_CHR_LOW: kind = CMD_CHR;
                default:    kind = CMD_NONE;
            endcase
        end
    end

    // Gate the decoded kind with the qualified strobe.
    always_comb begin
        prg_load = wr_qual && (kind == CMD_PRG);
        chr_load = wr_qual && (kind == CMD_CHR);
        bank_nib = cpu_addr[3:0];
    end
endmodule

// File: rtl/abm_prg_unit.sv
// Module: abm_prg_unit
// Holds the base page of the switchable upper 16 KB CPU window and
// translates CPU addresses into program-ROM addresses.
// Assumes PRG_PAGES is even and at least 4, so base+1 never wraps.
module abm_prg_unit #(
    parameter  int PRG_PAGES = 16,
    localparam int PW        = $clog2(PRG_PAGES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [3:0]     bank_nib,
    input  logic [14:0]    cpu_off,
    output logic [PW+12:0] prg_addr,
    output logic [PW-1:0]  hi_base
);
    localparam int SLOTS = 4;

    logic [PW-1:0] next_base;
    logic [PW-1:0] slot_page [SLOTS];

    // Wrap the doubled bank number into the program page range.
    always_comb next_base = PW'((32'(bank_nib) * 2) % PRG_PAGES);

    // Base register for slot 2; slot 3 follows it.
    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_base <= PW'(PRG_PAGES - 2);
        else if (load)
            hi_base <= next_base;
    end

    // Per-slot page table: two fixed slots, two switchable slots.
    for (genvar s = 0; s < SLOTS; s++) begin : g_slot
        if (s < 2) begin : g_fixed
            assign slot_page[s] = PW'(s);
        end else begin : g_switch
            assign slot_page[s] = hi_base + PW'(s - 2);
        end
    end

    assign prg_addr = {slot_page[cpu_off[14:13]], cpu_off[12:0]};
endmodule

// File: rtl/abm_chr_unit.sv
// Module: abm_chr_unit
// Holds the 8 KB-aligned character base and translates the video
// address through eight consecutive 1 KB slots.
// Assumes CHR_PAGES is a multiple of 8 and at least 8.
module abm_chr_unit #(
    parameter  int CHR_PAGES = 64,
    localparam int CW        = $clog2(CHR_PAGES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [3:0]     bank_nib,
    input  logic [12:0]    ppu_addr,
    output logic [CW+9:0]  chr_addr,
    output logic [CW-1:0]  base
);
    localparam int SLOTS = 8;

    logic [CW-1:0] next_base;
    logic [CW-1:0] slot_page [SLOTS];

    // Wrap eight times the bank number into the character page range.
    always_comb next_base = CW'((32'(bank_nib) * 8) % CHR_PAGES);

    // Character base register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base <= '0;
        else if (load)
            base <= next_base;
    end

    // Slot k maps to base plus k.
    for (genvar k = 0; k < SLOTS; k++) begin : g_slot
        assign slot_page[k] = base + CW'(k);
    end

    assign chr_addr = {slot_page[ppu_addr[12:10]], ppu_addr[9:0]};
endmodule

// File: rtl/addr_latched_bank_mapper.sv
// Module: addr_latched_bank_mapper
// Top of the cartridge mapper. It qualifies CPU writes to the upper
// 32 KB, decodes the address low byte as a command, and drives the
// translated program and character ROM addresses.
// Assumes PRG_PAGES is even and >= 4, and CHR_PAGES is a multiple of 8.
// cpu_wdata is accepted only for pin compatibility and is not used.
module addr_latched_bank_mapper #(
    parameter  int PRG_PAGES = 16,
    parameter  int CHR_PAGES = 64,
    localparam int PW        = $clog2(PRG_PAGES),
    localparam int CW        = $clog2(CHR_PAGES)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cpu_wr,
    input  logic [15:0]    cpu_addr,
    input  logic [7:0]     cpu_wdata,
    input  logic [12:0]    ppu_addr,
    output logic [PW+12:0] prg_addr,
    output logic [CW+9:0]  chr_addr
);
    logic          wr_qual;
    logic          prg_load;
    logic          chr_load;
    logic [3:0]    bank_nib;
    logic [PW-1:0] prg_hi_base;
    logic [CW-1:0] chr_base;
    logic          unused_data;

    // Only writes with A15 high reach the register window.
    assign wr_qual     = cpu_wr & cpu_addr[15];
    assign unused_data = ^cpu_wdata;

    abm_cmd_decode u_dec (
        .wr_qual  (wr_qual),
        .cpu_addr (cpu_addr),
        .prg_load (prg_load),
        .chr_load (chr_load),
        .bank_nib (bank_nib)
    );

    abm_prg_unit #(.PRG_PAGES(PRG_PAGES)) u_prg (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (prg_load),
        .bank_nib (bank_nib),
        .cpu_off  (cpu_addr[14:0]),
        .prg_addr (prg_addr),
        .hi_base  (prg_hi_base)
    );

    abm_chr_unit #(.CHR_PAGES(CHR_PAGES)) u_chr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (chr_load),
        .bank_nib (bank_nib),
        .ppu_addr (ppu_addr),
        .chr_addr (chr_addr),
        .base     (chr_base)
    );
endmodule

// File: rtl/abm_checker.sv
// Module: abm_checker
// Property checks for addr_latched_bank_mapper, attached by bind.
// It recomputes the command rules from the ports on its own and
// compares them with the base registers and the translated outputs.
module abm_checker #(
    parameter  int PRG_PAGES = 16,
    parameter  int CHR_PAGES = 64,
    localparam int PW        = $clog2(PRG_PAGES),
    localparam int CW        = $clog2(CHR_PAGES)
) (
    input logic           clk,
    input logic           rst_n,
    input logic           cpu_wr,
    input logic [15:0]    cpu_addr,
    input logic [12:0]    ppu_addr,
    input logic [PW+12:0] prg_addr,
    input logic [CW+9:0]  chr_addr,
    input logic [PW-1:0]  prg_hi_base,
    input logic [CW-1:0]  chr_base
);
    logic is_wr, upper, is_prg, is_chr;
    int   exp_prg, exp_chr;

    // Independent view of the command rules.
    always_comb begin
        is_wr   = cpu_wr && cpu_addr[15];
        upper   = cpu_addr >= 16'h9000;
        is_prg  = is_wr && (upper ? cpu_addr[7:4] == 4'hD : cpu_addr[7:4] == 4'hB);
        is_chr  = is_wr && (upper ? cpu_addr[7:4] == 4'hE : cpu_addr[7:4] == 4'h7);
        exp_prg = (2 * int'(cpu_addr[3:0])) % PRG_PAGES;
        exp_chr = (8 * int'(cpu_addr[3:0])) % CHR_PAGES;
    end

    // R9: the lower 16 KB always maps to pages 0 and 1.
    assert_fixed_slots_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !cpu_addr[14] |-> (int'(prg_addr[PW+12:13]) == int'(cpu_addr[13])));

    // R11: the offsets pass through unchanged.
    assert_offsets_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (prg_addr[12:0] == cpu_addr[12:0]) && (chr_addr[9:0] == ppu_addr[9:0]));

    // R10: without a qualified write, both bases hold.
    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !is_wr |=> ($stable(prg_hi_base) && $stable(chr_base)));

    // R6: a qualified write with a rejected code changes nothing.
    assert_bad_op_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (is_wr && !is_prg && !is_chr) |=> ($stable(prg_hi_base) && $stable(chr_base)));

    // R7: a program load sets the wrapped, even base.
    assert_prg_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
        is_prg |=> (int'(prg_hi_base) == $past(exp_prg)) && $stable(chr_base));

    // R8: a character load sets the wrapped, 8-aligned base.
    assert_chr_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        is_chr |=> (int'(chr_base) == $past(exp_chr)) && $stable(prg_hi_base));

    // R7/R8: the bases always stay inside the ROM and stay aligned.
    assert_base_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(prg_hi_base) < PRG_PAGES) && !prg_hi_base[0] &&
        (int'(chr_base) < CHR_PAGES) && (chr_base[2:0] == 3'd0));
endmodule

bind addr_latched_bank_mapper abm_checker #(
    .PRG_PAGES(PRG_PAGES),
    .CHR_PAGES(CHR_PAGES)
) u_abm_checker (.*);

// File: tb/tb_addr_latched_bank_mapper.sv
`timescale 1ns/1ps
module tb_addr_latched_bank_mapper;
    localparam int P  = 12;
    localparam int C  = 40;
    localparam int PW = $clog2(P);
    localparam int CW = $clog2(C);
    localparam time CLK_PERIOD = 20ns;

    logic           clk = 0;
    logic           rst_n = 0;
    logic           cpu_wr = 0;
    logic [15:0]    cpu_addr = 16'h0000;
    logic [7:0]     cpu_wdata = 8'h00;
    logic [12:0]    ppu_addr = '0;
    logic [PW+12:0] prg_addr;
    logic [CW+9:0]  chr_addr;

    int checks = 0;
    int errors = 0;
    int m_prg, m_chr;

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_latched_bank_mapper #(.PRG_PAGES(P), .CHR_PAGES(C)) dut (.*);

    task automatic check_val(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Reference rules applied to the model after each write.
    task automatic model_update(input logic [15:0] a, input logic strobe);
        int n;
        logic up;
        n  = int'(a[3:0]);
        up = a >= 16'h9000;
        if (strobe && a[15]) begin
            if ((up && a[7:4] == 4'hD) || (!up && a[7:4] == 4'hB))
                m_prg = (2 * n) % P;
            else if ((up && a[7:4] == 4'hE) || (!up && a[7:4] == 4'h7))
                m_chr = (8 * n) % C;
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d, input logic strobe);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_wr = strobe;
        @(negedge clk);
        cpu_wr = 1'b0;
        model_update(a, strobe);
    endtask

    function automatic int prg_page(input int s);
        return (s < 2) ? s : m_prg + (s - 2);
    endfunction

    task automatic probe_prg(input int s, input string req);
        int off;
        off = int'($urandom_range(0, 8191));
        @(negedge clk);
        cpu_addr = 16'(32'h8000 | (s << 13) | off);
        #1;
        check_val({req, " R11 prg"}, int'(prg_addr), (prg_page(s) << 13) | off);
    endtask

    task automatic probe_chr(input int k, input string req);
        int off;
        off = int'($urandom_range(0, 1023));
        @(negedge clk);
        ppu_addr = 13'((k << 10) | off);
        #1;
        check_val({req, " R11 chr"}, int'(chr_addr), ((m_chr + k) << 10) | off);
    endtask

    task automatic probe_all(input string req);
        for (int s = 0; s < 4; s++) probe_prg(s, (s < 2) ? "R9" : req);
        for (int k = 0; k < 8; k++) probe_chr(k, req);
    endtask

    initial begin
        int unused_seed;
        unused_seed = int'($urandom(32'h5EED));
        m_prg = P - 2;
        m_chr = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 and R2: state right after reset.
        for (int s = 0; s < 4; s++) probe_prg(s, "R1");
        for (int k = 0; k < 8; k++) probe_chr(k, "R2");

        // R3: the command comes from the address; data has no effect.
        do_write(16'h8000, 8'hB3, 1'b1); probe_all("R3");
        do_write(16'h80B3, 8'h00, 1'b1); probe_all("R3");
        do_write(16'h8071, 8'hE5, 1'b1); probe_all("R3");

        // R4: codes for the upper region.
        do_write(16'h90D5, 8'hFF, 1'b1); probe_all("R4");
        do_write(16'hF0E4, 8'h12, 1'b1); probe_all("R4");

        // R5: codes for the lower region.
        do_write(16'h8FB1, 8'h00, 1'b1); probe_all("R5");
        do_write(16'h8A72, 8'h00, 1'b1); probe_all("R5");

        // R6: rejected codes, including those of the other region.
        do_write(16'h80D2, 8'h00, 1'b1); probe_all("R6");
        do_write(16'h80E3, 8'h00, 1'b1); probe_all("R6");
        do_write(16'h90B2, 8'h00, 1'b1); probe_all("R6");
        do_write(16'h9073, 8'h00, 1'b1); probe_all("R6");
        do_write(16'hC0A5, 8'h00, 1'b1); probe_all("R6");

        // R7: wrap of the program bank.
        do_write(16'hA0D6, 8'h00, 1'b1); probe_all("R7");
        do_write(16'hA0DF, 8'h00, 1'b1); probe_all("R7");

        // R8: wrap of the character bank.
        do_write(16'h9FE5, 8'h00, 1'b1); probe_all("R8");
        do_write(16'h9FE7, 8'h00, 1'b1); probe_all("R8");
        do_write(16'h9FEF, 8'h00, 1'b1); probe_all("R8");

        // R10: A15 low, or no strobe, changes nothing.
        do_write(16'h10D3, 8'h00, 1'b1); probe_all("R10");
        do_write(16'h0071, 8'h00, 1'b1); probe_all("R10");
        do_write(16'h90D1, 8'h00, 1'b0); probe_all("R10");

        // Random mix of writes with an occasional missing strobe.
        for (int i = 0; i < 400; i++) begin
            logic [15:0] a;
            logic [3:0]  op;
            int r;
            r  = int'($urandom_range(0, 5));
            op = (r == 0) ? 4'h7 : (r == 1) ? 4'hB : (r == 2) ? 4'hD :
                 (r == 3) ? 4'hE : 4'($urandom);
            a  = {1'b1, 15'($urandom)};
            a[7:4] = op;
            do_write(a, 8'($urandom), ($urandom_range(0, 9) != 0));
            probe_prg(int'($urandom_range(0, 3)), "R7");
            probe_chr(int'($urandom_range(0, 7)), "R8");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule